// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns a single CPU-side request into a complete external bus cycle. When it accepts a request it compares the physical address against four programmable address windows, each described by a base, a mask, an enable and two settings. The settings are the bus mode (address and data sharing one port, or on separate ports) and the data width. The lowest-numbered enabled window that matches supplies the settings. If no window matches, a fallback configuration applies. Software sets the windows up once, and no run-time switching is needed.

Each cycle starts with an address phase. In that phase the address-latch strobe is high and the address sits on the dedicated address port. In multiplexed mode the low address bits also appear on the shared address/data port. A read or write strobe phase of fixed length follows, and then a one-clock ready pulse goes back to the CPU. A read captures the shared port on the last strobe clock.

A multiplexed cycle may directly follow a de-multiplexed one. In that case the block inserts one turnaround clock, so the device selected before can release the shared port. During that clock the latch strobe is already high but the shared port stays undriven. As a result the latch strobe is one clock longer and the whole cycle is one clock longer. The selected mode and width are exported for a downstream width adapter.

Top module: `ebus_cycle_seq`

## Requirements
- R1: After reset, `ale` is 0, `rd_n` and `wr_n` are 1, `ready` is 0 and `ad_oe` is 0.
- R2: Window i matches when `win_en[i]` is 1 and `(addr & mask_i) == (base_i & mask_i)`. Window i uses bits `[i*ADDR_W +: ADDR_W]` of `win_base` and of `win_mask`. The matched window's `win_mux[i]` (1 = multiplexed) and `win_wide[i]` (1 = 16-bit) are presented on `cyc_mux` and `cyc_wide`, and its index is presented on `cyc_sel`. These outputs hold from the first clock after acceptance until the cycle ends.
- R3: When several enabled windows match, the lowest index wins.
- R4: When no enabled window matches, `cyc_sel` reads 4 and `cyc_mux`/`cyc_wide` take `dflt_mux`/`dflt_wide`.
- R5: A request is accepted at a clock edge where `req` is 1 and the block is idle. From the next clock on, `addr_out` carries the accepted address and holds it until the next acceptance. `ale` is high only during the address phase, never together with a read or write strobe.
- R6: In a multiplexed address phase, `ad_oe` is 1 and `ad_out` equals `addr[DATA_W-1:0]`. In a de-multiplexed address phase, `ad_oe` is 0.
- R7: When the accepted cycle is multiplexed and the previous completed cycle was de-multiplexed, one extra clock comes first. In that clock `ale` is 1 and `ad_oe` is 0, so `ale` spans two clocks and the cycle grows by one clock.
- R8: No extra clock is inserted for the first cycle after reset, for a cycle after a multiplexed cycle, or for any de-multiplexed cycle.
- R9: After the address phase, the strobe phase lasts STROBE_CYC clocks. During it `rd_n` is 0 for a read. For a write, `wr_n` is 0, `ad_oe` is 1 and `ad_out` equals the write data.
- R10: A read samples `ad_in` at the clock edge that ends the last strobe clock, and presents the sample on `rdata` while `ready` is 1.
- R11: `ready` is high for exactly one clock right after the strobe phase. After that clock the block is idle for at least one clock, and `req` has no effect while a cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | CPU request, sampled while idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Physical access address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid with ready |
| ready | output | 1 | One-clock completion pulse |
| win_base | input | NUM_WIN*ADDR_W | Window base addresses, packed |
| win_mask | input | NUM_WIN*ADDR_W | Window compare masks, packed |
| win_en | input | NUM_WIN | Window enables |
| win_mux | input | NUM_WIN | Window mode, 1 = multiplexed |
| win_wide | input | NUM_WIN | Window width, 1 = 16-bit |
| dflt_mux | input | 1 | Fallback mode |
| dflt_wide | input | 1 | Fallback width |
| ale | output | 1 | Address latch strobe |
| addr_out | output | ADDR_W | Dedicated address port |
| ad_out | output | DATA_W | Shared port drive value |
| ad_oe | output | 1 | Shared port drive enable |
| ad_in | input | DATA_W | Shared port receive value |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| cyc_mux | output | 1 | Mode of the current cycle |
| cyc_wide | output | 1 | Width of the current cycle |
| cyc_sel | output | SEL_W | Selected window, NUM_WIN = fallback |

## Verification
The bench aims at the mode history. It covers a multiplexed access right after reset, two multiplexed accesses in a row, and a chain of de-multiplexed accesses, none of which may gain a turnaround clock. It also covers de-multiplexed followed by multiplexed, where a missing turnaround clock would make the address appear on the shared port one clock early and leave `ale` one clock short. Overlapping windows and disabled windows test priority and fallback: a wrong priority order would report the wrong window index and mode. The read sample point is checked against an `ad_in` value that changes every clock, so sampling one clock off returns a different word. A request held high across several cycles shows that `req` has no effect while a cycle is in progress.

// File: rtl/ebus_pkg.sv
// Shared types for the external bus cycle sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package ebus_pkg;

    // Per-cycle bus settings chosen by the window decoder
    typedef struct packed {
        logic mux;   // 1 = address and data share the port
        logic wide;  // 1 = 16-bit data path
    } bus_cfg_t;

    // Sequencer phases
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_TURN = 3'd1,
        PH_ADDR = 3'd2,
        PH_STRB = 3'd3,
        PH_DONE = 3'd4
    } phase_e;

endpackage

// File: rtl/ebus_win_decode.sv
// Window decoder: compares an address with NUM_WIN base/mask windows and
// returns the lowest-index enabled hit, or the fallback settings.
// Assumes: purely combinational; the caller samples the result at accept.
module ebus_win_decode
    import ebus_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int NUM_WIN = 4,
    parameter int SEL_W   = $clog2(NUM_WIN + 1)
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_WIN*ADDR_W-1:0] win_base,
    input  logic [NUM_WIN*ADDR_W-1:0] win_mask,
    input  logic [NUM_WIN-1:0]        win_en,
    input  logic [NUM_WIN-1:0]        win_mux,
    input  logic [NUM_WIN-1:0]        win_wide,
    input  bus_cfg_t                  dflt_cfg,
    output logic [SEL_W-1:0]          sel_idx,
    output bus_cfg_t                  sel_cfg
);

    localparam logic [SEL_W-1:0] DFLT_IDX = SEL_W'(NUM_WIN);

    logic [NUM_WIN-1:0] hit;

    // One comparator per window
    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_cmp
        logic [ADDR_W-1:0] base_w;
        logic [ADDR_W-1:0] mask_w;
        assign base_w  = win_base[gi*ADDR_W +: ADDR_W];
        assign mask_w  = win_mask[gi*ADDR_W +: ADDR_W];
        assign hit[gi] = win_en[gi] && ((addr & mask_w) == (base_w & mask_w));
    end

    // Priority pick: scan downward so the lowest index overwrites last
    always_comb begin
        sel_idx = DFLT_IDX;
        sel_cfg = dflt_cfg;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel_idx      = SEL_W'(i);
                sel_cfg.mux  = win_mux[i];
                sel_cfg.wide = win_wide[i];
            end
        end
    end

endmodule

// File: rtl/ebus_turnaround.sv
// Mode history: remembers whether the last completed cycle was
// de-multiplexed and flags a turnaround when a multiplexed one follows.
// Assumes: done pulses once per finished cycle with done_mux valid.
module ebus_turnaround (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic done_mux,
    input  logic cur_mux,
    output logic penalty
);

    logic prev_demux;

    // Record the mode of each finished cycle; reset means "no history"
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_demux <= 1'b0;
        else if (done)
            prev_demux <= !done_mux;
    end

    // Turnaround only on a de-multiplexed to multiplexed change
    always_comb penalty = prev_demux && cur_mux;

    AST_NO_TURN_AFTER_MUX: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done) && $past(done_mux)) |-> !penalty); // R8

endmodule

// File: rtl/ebus_seq_fsm.sv
// Cycle sequencer: runs turnaround, address, strobe and ready phases for
// one accepted request and drives all external bus pins.
// Assumes: ADDR_W >= DATA_W, STROBE_CYC >= 1; cfg_in/sel_in/penalty are
// valid in the clock where req is seen while idle.
module ebus_seq_fsm
    import ebus_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 16,
    parameter int STROBE_CYC = 2,
    parameter int SEL_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  bus_cfg_t          cfg_in,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              penalty,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output bus_cfg_t          cyc_cfg,
    output logic [SEL_W-1:0]  cyc_sel,
    output logic              done
);

    localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CYC - 1);

    phase_e            state;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;
    logic              accept;

    assign accept = (state == PH_IDLE) && req;

    // Phase register and strobe counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                PH_IDLE: if (req) state <= penalty ? PH_TURN : PH_ADDR;
                PH_TURN: state <= PH_ADDR;
                PH_ADDR: begin
                    state <= PH_STRB;
                    cnt   <= CNT_LOAD;
                end
                PH_STRB: begin
                    if (cnt == '0) state <= PH_DONE;
                    else           cnt   <= cnt - 1'b1;
                end
                PH_DONE: state <= PH_IDLE;
                default: state <= PH_IDLE;
            endcase
        end
    end

    // Request capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            cyc_cfg <= '0;
            cyc_sel <= '0;
        end else if (accept) begin
            addr_q  <= addr;
            wdata_q <= wdata;
            we_q    <= we;
            cyc_cfg <= cfg_in;
            cyc_sel <= sel_in;
        end
    end

    // Read data sample on the last strobe clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (state == PH_STRB && cnt == '0 && !we_q)
            rdata <= ad_in;
    end

    // Pin decode from the current phase
    always_comb begin
        ale      = (state == PH_TURN) || (state == PH_ADDR);
        rd_n     = !((state == PH_STRB) && !we_q);
        wr_n     = !((state == PH_STRB) && we_q);
        ready    = (state == PH_DONE);
        done     = (state == PH_DONE);
        addr_out = addr_q;
        ad_oe    = 1'b0;
        ad_out   = '0;
        if (state == PH_ADDR && cyc_cfg.mux) begin
            ad_oe  = 1'b1;
            ad_out = addr_q[DATA_W-1:0];
        end else if (state == PH_STRB && we_q) begin
            ad_oe  = 1'b1;
            ad_out = wdata_q;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R9
    AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n)); // R5
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R11
    AST_TURN_THEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_TURN) |=> (ale && ad_oe)); // R7
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_IDLE && $past(state) != PH_IDLE) |-> $stable(addr_out)); // R5

endmodule

// File: rtl/ebus_cycle_seq.sv
// Top of the external bus cycle sequencer: window decode, mode history
// and phase sequencer wired together.
// Assumes: window settings are changed only while no cycle is running.
module ebus_cycle_seq
    import ebus_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 16,
    parameter int NUM_WIN    = 4,
    parameter int STROBE_CYC = 2,
    parameter int SEL_W      = $clog2(NUM_WIN + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    output logic                      ready,
    input  logic [NUM_WIN*ADDR_W-1:0] win_base,
    input  logic [NUM_WIN*ADDR_W-1:0] win_mask,
    input  logic [NUM_WIN-1:0]        win_en,
    input  logic [NUM_WIN-1:0]        win_mux,
    input  logic [NUM_WIN-1:0]        win_wide,
    input  logic                      dflt_mux,
    input  logic                      dflt_wide,
    output logic                      ale,
    output logic [ADDR_W-1:0]         addr_out,
    output logic [DATA_W-1:0]         ad_out,
    output logic                      ad_oe,
    input  logic [DATA_W-1:0]         ad_in,
    output logic                      rd_n,
    output logic                      wr_n,
    output logic                      cyc_mux,
    output logic                      cyc_wide,
    output logic [SEL_W-1:0]          cyc_sel
);

    bus_cfg_t         dflt_cfg;
    bus_cfg_t         dec_cfg;
    bus_cfg_t         cyc_cfg;
    logic [SEL_W-1:0] dec_sel;
    logic             penalty;
    logic             done;

    assign dflt_cfg = '{mux: dflt_mux, wide: dflt_wide};
    assign cyc_mux  = cyc_cfg.mux;
    assign cyc_wide = cyc_cfg.wide;

    ebus_win_decode #(
        .ADDR_W (ADDR_W),
        .NUM_WIN(NUM_WIN),
        .SEL_W  (SEL_W)
    ) u_dec (
        .addr    (addr),
        .win_base(win_base),
        .win_mask(win_mask),
        .win_en  (win_en),
        .win_mux (win_mux),
        .win_wide(win_wide),
        .dflt_cfg(dflt_cfg),
        .sel_idx (dec_sel),
        .sel_cfg (dec_cfg)
    );

    ebus_turnaround u_turn (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (done),
        .done_mux(cyc_cfg.mux),
        .cur_mux (dec_cfg.mux),
        .penalty (penalty)
    );

    ebus_seq_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .STROBE_CYC(STROBE_CYC),
        .SEL_W     (SEL_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .we      (we),
        .addr    (addr),
        .wdata   (wdata),
        .cfg_in  (dec_cfg),
        .sel_in  (dec_sel),
        .penalty (penalty),
        .ad_in   (ad_in),
        .ale     (ale),
        .addr_out(addr_out),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .ready   (ready),
        .rdata   (rdata),
        .cyc_cfg (cyc_cfg),
        .cyc_sel (cyc_sel),
        .done    (done)
    );

    AST_DONE_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ready && !ale)); // R11

endmodule

// File: tb/ebus_cycle_seq_tb.sv
// Bench: behavioural per-cycle reference model built from queues, compared
// with the design outputs on every falling edge.
module ebus_cycle_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 24;
    localparam int DATA_W     = 16;
    localparam int NUM_WIN    = 4;
    localparam int STROBE_CYC = 2;
    localparam int SEL_W      = 3;

    typedef struct {
        bit          idle;
        bit          ale;
        bit          rd_n;
        bit          wr_n;
        bit          oe;
        logic [15:0] ad;
        bit          rdy;
        bit          last;
    } rec_t;

    logic clk = 0;
    logic rst_n = 0;
    logic req = 0;
    logic we = 0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic ready;
    logic [NUM_WIN*ADDR_W-1:0] win_base = '0;
    logic [NUM_WIN*ADDR_W-1:0] win_mask = '0;
    logic [NUM_WIN-1:0] win_en = '0, win_mux = '0, win_wide = '0;
    logic dflt_mux = 0, dflt_wide = 0;
    logic ale, ad_oe, rd_n, wr_n, cyc_mux, cyc_wide;
    logic [ADDR_W-1:0] addr_out;
    logic [DATA_W-1:0] ad_out;
    logic [DATA_W-1:0] ad_in = '0;
    logic [SEL_W-1:0] cyc_sel;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ebus_cycle_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WIN(NUM_WIN),
        .STROBE_CYC(STROBE_CYC), .SEL_W(SEL_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready),
        .win_base(win_base), .win_mask(win_mask), .win_en(win_en),
        .win_mux(win_mux), .win_wide(win_wide),
        .dflt_mux(dflt_mux), .dflt_wide(dflt_wide),
        .ale(ale), .addr_out(addr_out), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .rd_n(rd_n), .wr_n(wr_n),
        .cyc_mux(cyc_mux), .cyc_wide(cyc_wide), .cyc_sel(cyc_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // ---------------- reference model ----------------
    rec_t        m_q[$];
    rec_t        m_cur;
    bit          m_prev_demux;
    logic [23:0] m_addr;
    bit          m_we;
    bit          m_mux, m_wide;
    int          m_sel;
    logic [15:0] m_rdata;

    function automatic rec_t idle_rec();
        rec_t r;
        r.idle = 1; r.ale = 0; r.rd_n = 1; r.wr_n = 1; r.oe = 0;
        r.ad = '0; r.rdy = 0; r.last = 0;
        return r;
    endfunction

    // Lowest enabled matching window, or NUM_WIN for the fallback
    function automatic int pick_window(input logic [23:0] a);
        for (int i = 0; i < NUM_WIN; i++) begin
            logic [23:0] b, m;
            b = win_base[i*ADDR_W +: ADDR_W];
            m = win_mask[i*ADDR_W +: ADDR_W];
            if (win_en[i] && ((a & m) == (b & m))) return i;
        end
        return NUM_WIN;
    endfunction

    task automatic build_cycle();
        rec_t r;
        bit pen;
        m_sel  = pick_window(addr);
        m_mux  = (m_sel == NUM_WIN) ? dflt_mux  : win_mux[m_sel];
        m_wide = (m_sel == NUM_WIN) ? dflt_wide : win_wide[m_sel];
        m_addr = addr;
        m_we   = we;
        pen    = m_prev_demux && m_mux;   // R7 / R8
        m_prev_demux = !m_mux;
        if (pen) begin
            r = idle_rec(); r.idle = 0; r.ale = 1;
            m_q.push_back(r);
        end
        r = idle_rec(); r.idle = 0; r.ale = 1; r.oe = m_mux; r.ad = addr[15:0];
        m_q.push_back(r);
        for (int k = 0; k < STROBE_CYC; k++) begin
            r = idle_rec(); r.idle = 0;
            r.rd_n = we; r.wr_n = !we; r.oe = we; r.ad = wdata;
            r.last = (k == STROBE_CYC - 1);
            m_q.push_back(r);
        end
        r = idle_rec(); r.idle = 0; r.rdy = 1;
        m_q.push_back(r);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_q.delete();
            m_cur = idle_rec();
            m_prev_demux = 0;
            m_addr = '0; m_we = 0; m_mux = 0; m_wide = 0; m_sel = 0;
            m_rdata = '0;
        end else begin
            if (m_cur.last && !m_we) m_rdata = ad_in;        // R10
            if (m_q.size() == 0 && m_cur.idle && req) build_cycle();
            if (m_q.size() > 0) m_cur = m_q.pop_front();
            else                m_cur = idle_rec();
        end
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog R11: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    // Shared port input changes every clock so a mistimed sample is visible
    always @(negedge clk) ad_in <= 16'h5A00 + 16'(cyc * 7);

    // Per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && cyc > 0) begin
            chk("R5 R7 ale", 32'(ale), 32'(m_cur.ale));
            chk("R9 rd_n", 32'(rd_n), 32'(m_cur.rd_n));
            chk("R9 wr_n", 32'(wr_n), 32'(m_cur.wr_n));
            chk("R6 R7 R8 ad_oe", 32'(ad_oe), 32'(m_cur.oe));
            if (m_cur.oe) chk("R6 R9 ad_out", 32'(ad_out), 32'(m_cur.ad));
            chk("R11 ready", 32'(ready), 32'(m_cur.rdy));
            if (m_cur.rdy && !m_we) chk("R10 rdata", 32'(rdata), 32'(m_rdata));
            chk("R5 addr_out", 32'(addr_out), 32'(m_addr));
            if (!m_cur.idle) begin
                chk("R2 R3 R4 cyc_sel", 32'(cyc_sel), 32'(m_sel));
                chk("R2 R4 cyc_mux", 32'(cyc_mux), 32'(m_mux));
                chk("R2 R4 cyc_wide", 32'(cyc_wide), 32'(m_wide));
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (!(m_q.size() == 0 && m_cur.idle)) @(negedge clk);
    endtask

    task automatic xfer(input bit w, input logic [23:0] a, input logic [15:0] d);
        wait_idle();
        req = 1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 0;
        wait_idle();
    endtask

    task automatic set_win(input int i, input logic [23:0] b, input logic [23:0] m,
                           input bit en, input bit mx, input bit wd);
        win_base[i*ADDR_W +: ADDR_W] = b;
        win_mask[i*ADDR_W +: ADDR_W] = m;
        win_en[i] = en; win_mux[i] = mx; win_wide[i] = wd;
    endtask

    initial begin
        set_win(0, 24'h100000, 24'hF00000, 1, 1, 1);
        set_win(1, 24'h200000, 24'hF00000, 1, 0, 1);
        set_win(2, 24'h120000, 24'hFF0000, 1, 0, 0);
        set_win(3, 24'h300000, 24'hF00000, 0, 1, 0);
        dflt_mux = 0; dflt_wide = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ale", 32'(ale), 0);
        chk("R1 rd_n", 32'(rd_n), 1);
        chk("R1 wr_n", 32'(wr_n), 1);
        chk("R1 ready", 32'(ready), 0);
        chk("R1 ad_oe", 32'(ad_oe), 0);
        rst_n = 1;
        // R8: multiplexed right after reset, no turnaround
        xfer(0, 24'h100010, 16'h0000);
        // de-multiplexed write in window 1
        xfer(1, 24'h200020, 16'hBEEF);
        // R3 overlap of 0 and 2, window 0 wins; R7 turnaround after demux
        xfer(0, 24'h123456, 16'h0000);
        // R8 multiplexed after multiplexed
        xfer(1, 24'h101234, 16'hC0DE);
        // R4 disabled window 3 falls back to default (demux)
        xfer(0, 24'h300000, 16'h0000);
        // R8 demux after demux
        xfer(1, 24'h7FFF00, 16'h1234);
        // R2 enable window 3 (mux): turnaround again
        set_win(3, 24'h300000, 24'hF00000, 1, 1, 0);
        xfer(1, 24'h3000AA, 16'h5555);
        // R3 with window 0 off, window 2 now selected
        win_en[0] = 0;
        xfer(0, 24'h123456, 16'h0000);
        win_en[0] = 1;
        // R11 req held high across cycles: only accepted while idle
        wait_idle();
        req = 1; we = 0; addr = 24'h100002; wdata = 16'h0;
        repeat (14) @(negedge clk);
        req = 0;
        wait_idle();
        xfer(1, 24'h200000, 16'hA5A5);
        xfer(0, 24'h1FFFFE, 16'h0000);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule